// File: doc/BRIEF.md
# Multi-Source Event Counter Bank

This block keeps four 40-bit event counters for system-level performance measurement. Each counter has its own 8-bit source code, which chooses one event from a fixed table. The table covers bus-clock cycles, address-bus activity, arbitration losses on the address and data buses, grants on which the winner issued a NOP, address-trap hits and debug-event notifications from two CPUs. The block takes raw arbiter signals (request vectors, grant and NOP strobes) and derives the loss and granted-but-idle events itself. Trap hits and debug pins arrive as ready-made inputs.

Software uses a plain register port. Address 0 holds the configuration word: four source fields, a self-clearing clear command and a global run enable. Addresses 4 to 7 hold the counters. Each counter reads back as its count with a sticky overflow flag above it, and software can write a counter to preload it. The bank has a single enable shared by all four counters. When any counter reaches its maximum count, hardware drops that enable, so all four counters freeze on the same edge and the captured values stay consistent with each other. The block is clocked by the bus clock.

Top module: `perf_event_bank`

## Requirements
- R1: After reset the configuration word reads 0 (all sources off, enable low), and each counter reads with its overflow flag (bit 40) at 0 and its count at 0.
- R2: The configuration word at address 0 holds the source field for counter k at bits 8k+7:8k. The run enable is bit 33. The clear command is bit 32 and always reads 0. Bits 63:34 always read 0.
- R3: A configuration write with bit 32 set zeroes every count and every overflow flag on that edge, even if an increment is due in the same cycle.
- R4: While the enable is 1, a counter advances by exactly one on each clock edge at which its selected event is present. When the enable is 0 it never advances.
- R5: Source code 0x00 and every code above 0x0C never count. Code 0x01 counts every clock cycle.
- R6: Code 0x02 counts cycles in which the address bus is busy. Codes 0x05, 0x06, 0x07 and 0x08 count cycles in which trap hit input 0, 1, 2 or 3 is high.
- R7: Codes 0x03 (address bus) and 0x09 (data bus) count cycles in which two or more request bits of that bus are set. A single requester never counts.
- R8: Codes 0x04 (address bus) and 0x0A (data bus) count cycles in which that bus's grant and NOP inputs are both high. A NOP without a grant does not count.
- R9: Codes 0x0B and 0x0C count rising edges of CPU debug input 0 and 1. A level held high for many cycles counts once.
- R10: An increment that brings any counter to all ones clears the enable on the same edge. All counters stop there, and the full counter holds its all-ones value.
- R11: An increment of a counter already at all ones wraps it to 0, sets its overflow flag and clears the enable. The flag stays set until a clear or a counter write.
- R12: Counter k reads and writes at address 4+k: count in bits 39:0, overflow flag in bit 40, bits 63:41 reading 0. A write loads both fields and takes priority over a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 configuration, 4 to 7 counters) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr, combinational |
| addr_busy | input | 1 | Address bus carries a transaction this cycle |
| addr_req | input | 4 | Address-bus arbitration requests |
| addr_gnt | input | 1 | Address bus granted this cycle |
| addr_nop | input | 1 | Address-bus winner drives a NOP command |
| data_req | input | 4 | Data-bus arbitration requests |
| data_gnt | input | 1 | Data bus granted this cycle |
| data_nop | input | 1 | Data-bus winner drives a NOP command |
| trap_hit | input | 4 | Address trap comparator hit pulses |
| cpu_dbg | input | 2 | Debug event notification lines from CPU 0 and CPU 1 |

## Verification
Every source code is tried with a pattern that should count and with a near miss that should not. The near misses are a lone requester against a pair, a NOP without a grant, a neighbouring trap line, the other CPU's debug line, and codes 0x00, 0x0D and 0xFF with every event input high. These pairs tell a correct decode apart from an off-by-one or swapped table entry. A second run sets four different sources at once with overlapping stimulus, which shows that each field drives its own counter. Directed runs preload counters next to all ones to separate stop-at-maximum from wrap-with-overflow. They also place a clear and a write on the same edge as an increment to show which one wins.

// File: rtl/perf_pkg.sv
package perf_pkg;
  // Event slot indices; each index equals the source code that selects it.
  localparam int EV_OFF    = 0;
  localparam int EV_CYCLE  = 1;
  localparam int EV_ABUSY  = 2;
  localparam int EV_ALOSS  = 3;
  localparam int EV_ANOP   = 4;
  localparam int EV_TRAP0  = 5;
  localparam int EV_DLOSS  = 9;
  localparam int EV_DNOP   = 10;
  localparam int EV_DBG0   = 11;
  localparam int NUM_TRAP  = 4;
  localparam int NUM_CPU   = 2;
  localparam int EVT_N     = 13;
endpackage

// File: rtl/perf_evt_decode.sv
module perf_evt_decode
  import perf_pkg::*;
#(
  parameter int REQ_N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_busy,
  input  logic [REQ_N-1:0]    addr_req,
  input  logic                addr_gnt,
  input  logic                addr_nop,
  input  logic [REQ_N-1:0]    data_req,
  input  logic                data_gnt,
  input  logic                data_nop,
  input  logic [NUM_TRAP-1:0] trap_hit,
  input  logic [NUM_CPU-1:0]  cpu_dbg,
  output logic [EVT_N-1:0]    evt
);
  logic [NUM_CPU-1:0] dbg_q;

  // previous debug levels, for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_q <= '0;
    else        dbg_q <= cpu_dbg;
  end

  always_comb begin
    evt = '0;
    evt[EV_OFF]   = 1'b0;
    evt[EV_CYCLE] = 1'b1;
    evt[EV_ABUSY] = addr_busy;
    evt[EV_ALOSS] = ($countones(addr_req) >= 2);
    evt[EV_ANOP]  = addr_gnt & addr_nop;
    evt[EV_TRAP0 +: NUM_TRAP] = trap_hit;
    evt[EV_DLOSS] = ($countones(data_req) >= 2);
    evt[EV_DNOP]  = data_gnt & data_nop;
    evt[EV_DBG0 +: NUM_CPU] = cpu_dbg & ~dbg_q;
  end

  // R9: a held debug level yields one event, never two in a row
  a_r9_dbg0_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EV_DBG0] |=> !evt[EV_DBG0]);
  a_r9_dbg1_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EV_DBG0+1] |=> !evt[EV_DBG0+1]);
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 40,
  parameter int SEL_W = 8,
  parameter int EVT_N = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W:0]   wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             hit
);
  localparam int IDX_W = $clog2(EVT_N);
  localparam logic [CNT_W-1:0] PRE_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             sel_evt, inc, at_max, ld;

  always_comb begin
    sel_evt = 1'b0;
    if (sel < SEL_W'(EVT_N)) sel_evt = evt[sel[IDX_W-1:0]];
  end

  assign at_max = &cnt_q;
  assign inc    = run & sel_evt & ~clr & ~wr;
  assign hit    = inc & (at_max | (cnt_q == PRE_MAX));
  assign ld     = clr | wr | inc;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (wr) begin
      cnt_d = wdata[CNT_W-1:0];
      ovf_d = wdata[CNT_W];
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      ovf_d = ovf_q | at_max;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (ld) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  // R3: clear leaves a zero count and flag
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !ovf_q));
  // R4: stopped counter holds unless software writes it
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr) |=> $stable(cnt_q));
  // R11: overflow flag is sticky
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr && !wr) |=> ovf_q);
  // R11: increment at all ones wraps to zero with the flag set
  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_max) |=> (cnt_q == '0 && ovf_q));
endmodule

// File: rtl/perf_event_bank.sv
module perf_event_bank
  import perf_pkg::*;
#(
  parameter int CNT_W   = 40,
  parameter int SEL_W   = 8,
  parameter int NUM_CNT = 4,
  parameter int REQ_N   = 4,
  parameter int ADDR_W  = 3,
  parameter int REG_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                addr_busy,
  input  logic [REQ_N-1:0]    addr_req,
  input  logic                addr_gnt,
  input  logic                addr_nop,
  input  logic [REQ_N-1:0]    data_req,
  input  logic                data_gnt,
  input  logic                data_nop,
  input  logic [NUM_TRAP-1:0] trap_hit,
  input  logic [NUM_CPU-1:0]  cpu_dbg
);
  localparam int CLR_BIT  = NUM_CNT * SEL_W;
  localparam int EN_BIT   = CLR_BIT + 1;
  localparam int CFG_ADDR = 0;
  localparam int CNT_BASE = 4;

  logic                rst_meta, rst_sync_n;
  logic [EVT_N-1:0]    evt;
  logic [SEL_W-1:0]    sel_q [NUM_CNT];
  logic                en_q, en_d, en_ld;
  logic                cfg_wr, clr;
  logic [NUM_CNT-1:0]  cnt_wr, hit_w, ovf_w;
  logic [CNT_W-1:0]    cnt_w [NUM_CNT];
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:EN_BIT+1];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  assign cfg_wr = reg_wr && (reg_addr == ADDR_W'(CFG_ADDR));
  assign clr    = cfg_wr && reg_wdata[CLR_BIT];

  perf_evt_decode #(.REQ_N(REQ_N)) evt_i (
    .clk(clk), .rst_n(rst_sync_n),
    .addr_busy(addr_busy), .addr_req(addr_req), .addr_gnt(addr_gnt), .addr_nop(addr_nop),
    .data_req(data_req), .data_gnt(data_gnt), .data_nop(data_nop),
    .trap_hit(trap_hit), .cpu_dbg(cpu_dbg), .evt(evt)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_wr[g] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + g));
    perf_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .EVT_N(EVT_N)) cnt_i (
      .clk(clk), .rst_n(rst_sync_n), .evt(evt), .sel(sel_q[g]),
      .run(en_q), .clr(clr), .wr(cnt_wr[g]), .wdata(reg_wdata[CNT_W:0]),
      .cnt(cnt_w[g]), .ovf(ovf_w[g]), .hit(hit_w[g])
    );
  end

  // source fields
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '0;
    end else if (cfg_wr) begin
      for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= reg_wdata[i*SEL_W +: SEL_W];
    end
  end

  // global enable: hardware stop beats a software write
  always_comb begin
    en_ld = cfg_wr | (|hit_w);
    en_d  = (|hit_w) ? 1'b0 : reg_wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  en_q <= 1'b0;
    else if (en_ld)   en_q <= en_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CFG_ADDR)) begin
      reg_rdata[EN_BIT] = en_q;
      for (int i = 0; i < NUM_CNT; i++) reg_rdata[i*SEL_W +: SEL_W] = sel_q[i];
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + i)) reg_rdata[CNT_W:0] = {ovf_w[i], cnt_w[i]};
    end
  end

  // R10: any counter reaching the top stops the bank
  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|hit_w) |=> !en_q);
  // R2: clear bit and reserved field read as zero
  a_r2_cfg_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == ADDR_W'(CFG_ADDR)) |-> (reg_rdata[REG_W-1:EN_BIT+1] == '0 && !reg_rdata[CLR_BIT]));
  // R12: counter reads keep the upper bits zero
  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr >= ADDR_W'(CNT_BASE)) |-> (reg_rdata[REG_W-1:CNT_W+1] == '0));
endmodule

// File: tb/perf_event_bank_tb.sv
`timescale 1ns/100ps
module perf_event_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        addr_busy, addr_gnt, addr_nop, data_gnt, data_nop;
  logic [3:0]  addr_req, data_req, trap_hit;
  logic [1:0]  cpu_dbg;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  perf_event_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_busy(addr_busy), .addr_req(addr_req), .addr_gnt(addr_gnt), .addr_nop(addr_nop),
    .data_req(data_req), .data_gnt(data_gnt), .data_nop(data_nop),
    .trap_hit(trap_hit), .cpu_dbg(cpu_dbg)
  );

  typedef struct packed {
    logic [7:0] code;
    logic       abusy;
    logic [3:0] areq;
    logic       agnt;
    logic       anop;
    logic [3:0] dreq;
    logic       dgnt;
    logic       dnop;
    logic [3:0] trap;
    logic [1:0] dbg;
    logic [7:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 16;
  // each vector: source on counter 0, stimulus held 5 edges
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 2'b11, 8'd0, 4'd5}, // R5 off
    '{8'h01, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b00, 8'd6, 4'd5}, // R5 cycles
    '{8'h02, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b00, 8'd5, 4'd6}, // R6 busy
    '{8'h03, 1'b0, 4'h1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b00, 8'd0, 4'd7}, // R7 lone
    '{8'h03, 1'b0, 4'h6, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b00, 8'd5, 4'd7}, // R7 pair
    '{8'h09, 1'b0, 4'h0, 1'b0, 1'b0, 4'hB, 1'b0, 1'b0, 4'h0, 2'b00, 8'd5, 4'd7}, // R7 data
    '{8'h04, 1'b0, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b00, 8'd0, 4'd8}, // R8 no nop
    '{8'h04, 1'b0, 4'h0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 2'b00, 8'd5, 4'd8}, // R8 addr
    '{8'h0A, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'h0, 2'b00, 8'd5, 4'd8}, // R8 data
    '{8'h0A, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 2'b00, 8'd0, 4'd8}, // R8 no gnt
    '{8'h07, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h4, 2'b00, 8'd5, 4'd6}, // R6 trap2
    '{8'h05, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'hE, 2'b00, 8'd0, 4'd6}, // R6 trap0 idle
    '{8'h0B, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b01, 8'd1, 4'd9}, // R9 cpu0
    '{8'h0C, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 2'b01, 8'd0, 4'd9}, // R9 cpu1 idle
    '{8'h0D, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 2'b11, 8'd0, 4'd5}, // R5 0x0D
    '{8'hFF, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 4'hF, 2'b11, 8'd0, 4'd5}  // R5 0xFF
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] cfgw(input logic [7:0] s3, s2, s1, s0, input logic en, cl);
    return {30'b0, en, cl, s3, s2, s1, s0};
  endfunction

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wreg(input logic [2:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic stim(input vec_t v);
    addr_busy = v.abusy; addr_req = v.areq; addr_gnt = v.agnt; addr_nop = v.anop;
    data_req = v.dreq; data_gnt = v.dgnt; data_nop = v.dnop;
    trap_hit = v.trap; cpu_dbg = v.dbg;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    vec_t zero;
    zero = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    stim(zero);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rreg(3'd0, rd); chk("R1 cfg", rd, 64'h0);
    for (int k = 0; k < 4; k++) begin
      rreg(3'(4 + k), rd); chk("R1 counter", rd, 64'h0);
    end

    // table walk: counter 0 per source code
    for (int n = 0; n < NV; n++) begin
      wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, VECS[n].code, 1'b1, 1'b1));
      stim(VECS[n]);
      repeat (5) @(negedge clk);
      stim(zero);
      wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, VECS[n].code, 1'b0, 1'b0));
      rreg(3'd4, rd);
      checks++;
      if (rd !== {56'h0, VECS[n].exp}) begin
        errors++;
        $display("FAIL R%0d code %h: got %h expected %h", VECS[n].rq, VECS[n].code, rd, {56'h0, VECS[n].exp});
      end
    end

    // R2 field placement: four sources at once, reserved write bits dropped
    wreg(3'd0, 64'hFFFF_FFFC_0000_0000 | cfgw(8'h0C, 8'h0B, 8'h03, 8'h02, 1'b1, 1'b1));
    rreg(3'd0, rd); chk("R2 cfg readback", rd, 64'h0000_0002_0C0B_0302);
    addr_busy = 1'b1; addr_req = 4'h3; cpu_dbg = 2'b10;
    repeat (2) @(negedge clk);
    addr_req = 4'h0;
    @(negedge clk);
    stim(zero);
    wreg(3'd0, cfgw(8'h0C, 8'h0B, 8'h03, 8'h02, 1'b0, 1'b0));
    rreg(3'd4, rd); chk("R2 field0 busy", rd, 64'd3);
    rreg(3'd5, rd); chk("R2 field1 loss", rd, 64'd2);
    rreg(3'd6, rd); chk("R2 field2 dbg0", rd, 64'd0);
    rreg(3'd7, rd); chk("R2 field3 dbg1", rd, 64'd1);

    // R12 preload with flag, upper bits ignored
    wreg(3'd5, 64'hFFFF_FF00_0000_1234);
    rreg(3'd5, rd); chk("R12 preload", rd, 64'h0000_0100_0000_1234);

    // R3 clear beats a due increment and resets flags
    wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b1));
    rreg(3'd4, rd); chk("R3 clear vs inc", rd, 64'h0);
    rreg(3'd5, rd); chk("R3 clear flag", rd, 64'h0);

    // R12 write beats increment while running
    wreg(3'd4, 64'h50);
    rreg(3'd4, rd); chk("R12 write wins", rd, 64'h50);
    wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0));
    rreg(3'd4, rd); chk("R4 last edge", rd, 64'h51);

    // R10 stop on reaching all ones; neighbour freezes too
    wreg(3'd4, 64'h00FF_FFFF_FFFD);
    wreg(3'd6, 64'd100);
    wreg(3'd0, cfgw(8'h00, 8'h01, 8'h00, 8'h01, 1'b1, 1'b0));
    repeat (6) @(negedge clk);
    rreg(3'd4, rd); chk("R10 full holds", rd, 64'h00FF_FFFF_FFFF);
    rreg(3'd6, rd); chk("R10 neighbour frozen", rd, 64'd102);
    rreg(3'd0, rd); chk("R10 enable low", rd, 64'h0000_0000_0001_0001);

    // R11 wrap from all ones
    wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    rreg(3'd4, rd); chk("R11 wrap", rd, 64'h0000_0100_0000_0000);
    rreg(3'd0, rd); chk("R11 enable low", rd, 64'h1);
    wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    wreg(3'd0, cfgw(8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0));
    rreg(3'd4, rd); chk("R11 sticky", rd, 64'h0000_0100_0000_0004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule